// File: doc/BRIEF.md
# Fault-tolerant five-level bridge gate-pattern selector

This block turns a requested switching state into the twelve gate commands of one single-phase, five-level, neutral-point-clamped bridge. The bridge has two legs, A and B, of four series switches each (A1..A4 and B1..B4, numbered top to bottom), a clamp-diode pair per leg, and four bypass switches: X1 joins leg A's output to the positive rail, X2 joins it to the negative rail, X3 and X4 do the same for leg B. A modulator presents a state number every cycle. States 1 to 9 are the ordinary patterns. States 10 to 17 use a bypass switch and are only reached when a leg switch has failed.

A separate diagnosis unit reports at most one failed part through a code and a strobe. From that report onward the block stays in a fault-tolerant mode. Any requested state whose current path crosses the failed part is replaced by a state that gives the same terminal level: another ordinary state or a bypass state. The replacement applies in the very cycle the report arrives, so there is no gap in the gate stream. The twelve gates and an invalid-state flag are registered.

Top module: `npc_ft_gate_sel`

## Requirements
- R1: While `rst` is high at a clock edge, `gate`, `state_err` and `ft_active` are all 0 after that edge.
- R2: `gate` bits 11..8 drive A1..A4, bits 7..4 drive B1..B4, bits 3..0 drive X1..X4. With no fault latched, ordinary states give these patterns (hex): 1=C30, 2=C60, 3=630, 4=CC0, 5=660, 6=330, 7=6C0, 8=360, 9=3C0.
- R3: Bypass states give: 10=038, 11=068, 12=0C4, 13=064, 14=302, 15=602, 16=C01, 17=601. At most one bypass gate is on. When X1 or X2 is on, A1..A4 are off. When X3 or X4 is on, B1..B4 are off. Bypass gates stay off unless a leg-switch fault is latched.
- R4: `fault_code` values: 1 = leg A clamp pair, 2 = leg B clamp pair, 3..6 = A1..A4, 7..10 = B1..B4. A strobe with a code in 1..10 latches it until reset. `ft_active` rises one cycle after the strobe.
- R5: A strobe is ignored when its code is 0 or 11..15, or when a fault is already latched. Mapping and `ft_active` are unchanged by it.
- R6: Clamp faults. Code 1 maps 3->2, 5->4, 7->8. Code 2 maps 2->3, 5->4, 8->7.
- R7: Leg A switch faults. Code 3 maps 1->10, 2->11, 4->5. Code 4 maps 1->10, 2->11, 3->11, 4->6, 5->6, 7->8. Code 5 maps 3->2, 5->4, 6->4, 7->13, 8->13, 9->12. Code 6 maps 6->4, 8->13, 9->12.
- R8: Leg B switch faults. Code 7 maps 4->5, 7->15, 9->14. Code 8 maps 2->3, 4->6, 5->6, 7->15, 8->15, 9->14. Code 9 maps 1->16, 2->17, 3->17, 5->4, 6->4, 8->7. Code 10 maps 1->16, 3->17, 6->4. Under any latched leg-switch fault, that switch's gate is never on.
- R9: A requested state of 0 or 10..15 gives `gate` = 000 and `state_err` = 1. Otherwise `state_err` = 0.
- R10: `gate` and `state_err` reflect the inputs of the previous clock edge. A fault strobed at an edge already remaps the state requested at that same edge.
- R11: A1 and A3, A2 and A4, B1 and B3, B2 and B4 are never on together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_state | input | STATE_W | Requested switching state |
| fault_vld | input | 1 | Fault report strobe |
| fault_code | input | FAULT_W | Failed-part code |
| gate | output | 12 | Registered gate commands |
| state_err | output | 1 | Registered invalid-state flag |
| ft_active | output | 1 | Fault-tolerant mode latched |

## Verification
Two functions can meet in one cycle: latching a fault report, and remapping the state requested at the same edge. The sweep strobes each fault code together with every state request, starting with the first request after reset. The state sampled with the strobe must therefore already come out substituted one cycle later. A second, different report is also strobed alongside a request once a fault is latched, and must leave the first fault's substitution in place.

// File: rtl/npc_ft_pkg.sv
package npc_ft_pkg;

  localparam int LEG_GATES   = 4;
  localparam int N_LEGS      = 2;
  localparam int N_BYP       = 4;
  localparam int N_GATES     = N_LEGS * LEG_GATES + N_BYP;
  localparam int MAX_STATE   = 17;
  localparam int ID_W        = $clog2(MAX_STATE + 1);
  localparam int MAX_HEALTHY = 9;
  localparam int FLT_FIRST   = 1;
  localparam int FLT_LAST    = 10;

  typedef enum logic [1:0] {
    LEG_OFF,
    LEG_POS,
    LEG_MID,
    LEG_NEG
  } leg_lvl_e;

  typedef enum logic [3:0] {
    FLT_NONE    = 4'd0,
    FLT_CLAMP_A = 4'd1,
    FLT_CLAMP_B = 4'd2,
    FLT_A1      = 4'd3,
    FLT_A2      = 4'd4,
    FLT_A3      = 4'd5,
    FLT_A4      = 4'd6,
    FLT_B1      = 4'd7,
    FLT_B2      = 4'd8,
    FLT_B3      = 4'd9,
    FLT_B4      = 4'd10
  } fault_e;

  typedef struct packed {
    leg_lvl_e           leg_a;
    leg_lvl_e           leg_b;
    logic [N_BYP-1:0]   byp;
  } state_plan_t;

  // Per-state leg levels; terminal level = level(A) - level(B).
  function automatic state_plan_t plan_of(input logic [ID_W-1:0] id);
    state_plan_t p;
    p = '{leg_a: LEG_OFF, leg_b: LEG_OFF, byp: '0};
    case (id)
      5'd1:  p = '{leg_a: LEG_POS, leg_b: LEG_NEG, byp: 4'b0000};
      5'd2:  p = '{leg_a: LEG_POS, leg_b: LEG_MID, byp: 4'b0000};
      5'd3:  p = '{leg_a: LEG_MID, leg_b: LEG_NEG, byp: 4'b0000};
      5'd4:  p = '{leg_a: LEG_POS, leg_b: LEG_POS, byp: 4'b0000};
      5'd5:  p = '{leg_a: LEG_MID, leg_b: LEG_MID, byp: 4'b0000};
      5'd6:  p = '{leg_a: LEG_NEG, leg_b: LEG_NEG, byp: 4'b0000};
      5'd7:  p = '{leg_a: LEG_MID, leg_b: LEG_POS, byp: 4'b0000};
      5'd8:  p = '{leg_a: LEG_NEG, leg_b: LEG_MID, byp: 4'b0000};
      5'd9:  p = '{leg_a: LEG_NEG, leg_b: LEG_POS, byp: 4'b0000};
      5'd10: p = '{leg_a: LEG_OFF, leg_b: LEG_NEG, byp: 4'b1000};
      5'd11: p = '{leg_a: LEG_OFF, leg_b: LEG_MID, byp: 4'b1000};
      5'd12: p = '{leg_a: LEG_OFF, leg_b: LEG_POS, byp: 4'b0100};
      5'd13: p = '{leg_a: LEG_OFF, leg_b: LEG_MID, byp: 4'b0100};
      5'd14: p = '{leg_a: LEG_NEG, leg_b: LEG_OFF, byp: 4'b0010};
      5'd15: p = '{leg_a: LEG_MID, leg_b: LEG_OFF, byp: 4'b0010};
      5'd16: p = '{leg_a: LEG_POS, leg_b: LEG_OFF, byp: 4'b0001};
      5'd17: p = '{leg_a: LEG_MID, leg_b: LEG_OFF, byp: 4'b0001};
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/npc_fault_latch.sv
module npc_fault_latch
  import npc_ft_pkg::*;
#(
  parameter int FAULT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vld,
  input  logic [FAULT_W-1:0] code,
  output fault_e             eff,
  output logic               active
);

  logic   hit;
  fault_e held;

  assign hit = vld && (code >= FAULT_W'(FLT_FIRST)) && (code <= FAULT_W'(FLT_LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      held   <= FLT_NONE;
      active <= 1'b0;
    end else if (!active && hit) begin
      held   <= fault_e'(code[3:0]);
      active <= 1'b1;
    end
  end

  // A fresh report takes effect in its own cycle.
  always_comb begin
    if (active)   eff = held;
    else if (hit) eff = fault_e'(code[3:0]);
    else          eff = FLT_NONE;
  end

endmodule

// File: rtl/npc_state_remap.sv
module npc_state_remap
  import npc_ft_pkg::*;
(
  input  fault_e          flt,
  input  logic [ID_W-1:0] st,
  output logic [ID_W-1:0] mapped
);

  always_comb begin
    mapped = st;
    case (flt)
      FLT_CLAMP_A:
        case (st)
          5'd3: mapped = 5'd2;
          5'd5: mapped = 5'd4;
          5'd7: mapped = 5'd8;
          default: ;
        endcase
      FLT_CLAMP_B:
        case (st)
          5'd2: mapped = 5'd3;
          5'd5: mapped = 5'd4;
          5'd8: mapped = 5'd7;
          default: ;
        endcase
      FLT_A1:
        case (st)
          5'd1: mapped = 5'd10;
          5'd2: mapped = 5'd11;
          5'd4: mapped = 5'd5;
          default: ;
        endcase
      FLT_A2:
        case (st)
          5'd1: mapped = 5'd10;
          5'd2: mapped = 5'd11;
          5'd3: mapped = 5'd11;
          5'd4: mapped = 5'd6;
          5'd5: mapped = 5'd6;
          5'd7: mapped = 5'd8;
          default: ;
        endcase
      FLT_A3:
        case (st)
          5'd3: mapped = 5'd2;
          5'd5: mapped = 5'd4;
          5'd6: mapped = 5'd4;
          5'd7: mapped = 5'd13;
          5'd8: mapped = 5'd13;
          5'd9: mapped = 5'd12;
          default: ;
        endcase
      FLT_A4:
        case (st)
          5'd6: mapped = 5'd4;
          5'd8: mapped = 5'd13;
          5'd9: mapped = 5'd12;
          default: ;
        endcase
      FLT_B1:
        case (st)
          5'd4: mapped = 5'd5;
          5'd7: mapped = 5'd15;
          5'd9: mapped = 5'd14;
          default: ;
        endcase
      FLT_B2:
        case (st)
          5'd2: mapped = 5'd3;
          5'd4: mapped = 5'd6;
          5'd5: mapped = 5'd6;
          5'd7: mapped = 5'd15;
          5'd8: mapped = 5'd15;
          5'd9: mapped = 5'd14;
          default: ;
        endcase
      FLT_B3:
        case (st)
          5'd1: mapped = 5'd16;
          5'd2: mapped = 5'd17;
          5'd3: mapped = 5'd17;
          5'd5: mapped = 5'd4;
          5'd6: mapped = 5'd4;
          5'd8: mapped = 5'd7;
          default: ;
        endcase
      FLT_B4:
        case (st)
          5'd1: mapped = 5'd16;
          5'd3: mapped = 5'd17;
          5'd6: mapped = 5'd4;
          default: ;
        endcase
      default: ;
    endcase
  end

endmodule

// File: rtl/npc_leg_drive.sv
module npc_leg_drive
  import npc_ft_pkg::*;
(
  input  leg_lvl_e             lvl,
  output logic [LEG_GATES-1:0] g
);

  // Bits ordered top switch first; inner pair conducts for the mid level.
  always_comb begin
    case (lvl)
      LEG_POS: g = 4'b1100;
      LEG_MID: g = 4'b0110;
      LEG_NEG: g = 4'b0011;
      default: g = 4'b0000;
    endcase
  end

endmodule

// File: rtl/npc_ft_gate_sel.sv
module npc_ft_gate_sel
  import npc_ft_pkg::*;
#(
  parameter int STATE_W = 4,
  parameter int FAULT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STATE_W-1:0] req_state,
  input  logic               fault_vld,
  input  logic [FAULT_W-1:0] fault_code,
  output logic [11:0]        gate,
  output logic               state_err,
  output logic               ft_active
);

  fault_e              eff_fault;
  logic                in_range;
  logic [ID_W-1:0]     req_id;
  logic [ID_W-1:0]     sub_id;
  state_plan_t         plan;
  leg_lvl_e            leg_lvl  [N_LEGS];
  logic [LEG_GATES-1:0] leg_gate [N_LEGS];
  logic [N_GATES-1:0]  gate_d;
  logic [N_GATES-1:0]  gate_q;
  logic                err_q;

  npc_fault_latch #(.FAULT_W(FAULT_W)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .vld    (fault_vld),
    .code   (fault_code),
    .eff    (eff_fault),
    .active (ft_active)
  );

  assign in_range = (req_state != '0) && (req_state <= STATE_W'(MAX_HEALTHY));
  assign req_id   = ID_W'(req_state);

  npc_state_remap u_remap (
    .flt    (eff_fault),
    .st     (req_id),
    .mapped (sub_id)
  );

  assign plan       = plan_of(sub_id);
  assign leg_lvl[0] = plan.leg_a;
  assign leg_lvl[1] = plan.leg_b;

  for (genvar i = 0; i < N_LEGS; i++) begin : g_leg
    npc_leg_drive u_leg (
      .lvl (leg_lvl[i]),
      .g   (leg_gate[i])
    );
  end

  assign gate_d = {leg_gate[0], leg_gate[1], plan.byp};

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= '0;
      err_q  <= 1'b0;
    end else begin
      gate_q <= in_range ? gate_d : '0;
      err_q  <= !in_range;
    end
  end

  assign gate      = gate_q;
  assign state_err = err_q;

endmodule

// File: rtl/npc_ft_gate_sel_chk.sv
module npc_ft_gate_sel_chk
  import npc_ft_pkg::*;
#(
  parameter int STATE_W = 4,
  parameter int FAULT_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [STATE_W-1:0] req_state,
  input logic               fault_vld,
  input logic [FAULT_W-1:0] fault_code,
  input logic [11:0]        gate,
  input logic               state_err,
  input logic               ft_active
);

  logic       armed;
  logic       ck_on;
  logic [3:0] ck_code;
  logic [3:0] ck_idx;
  logic       ck_sw;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      ck_on   <= 1'b0;
      ck_code <= 4'd0;
    end else begin
      armed <= 1'b1;
      if (!ck_on && fault_vld && fault_code >= FAULT_W'(1) && fault_code <= FAULT_W'(10)) begin
        ck_on   <= 1'b1;
        ck_code <= fault_code[3:0];
      end
    end
  end

  assign ck_sw  = ck_on && (ck_code >= 4'd3);
  assign ck_idx = 4'd14 - ck_code;

  a_r11_no_shoot_thru: assert property (@(posedge clk) disable iff (rst)
    !(gate[11] && gate[9]) && !(gate[10] && gate[8]) &&
    !(gate[7] && gate[5]) && !(gate[6] && gate[4]));

  a_r9_err_blanks: assert property (@(posedge clk) disable iff (rst)
    state_err |-> (gate == 12'h000));

  a_r10_err_follows: assert property (@(posedge clk) disable iff (rst)
    armed |-> (state_err == (($past(req_state) == '0) || ($past(req_state) > STATE_W'(9)))));

  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    ft_active |=> ft_active);

  a_r3_one_bypass: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gate[3:0]));

  a_r3_bypass_leg_idle: assert property (@(posedge clk) disable iff (rst)
    ((gate[3] || gate[2]) |-> (gate[11:8] == 4'h0)) and
    ((gate[1] || gate[0]) |-> (gate[7:4] == 4'h0)));

  a_r3_bypass_healthy: assert property (@(posedge clk) disable iff (rst)
    !ck_sw |-> (gate[3:0] == 4'h0));

  // Covers R7 and R8: a failed leg switch is never commanded on.
  a_r7_r8_failed_switch_idle: assert property (@(posedge clk) disable iff (rst)
    ck_sw |-> !gate[ck_idx]);

endmodule

bind npc_ft_gate_sel npc_ft_gate_sel_chk #(.STATE_W(STATE_W), .FAULT_W(FAULT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_state  (req_state),
  .fault_vld  (fault_vld),
  .fault_code (fault_code),
  .gate       (gate),
  .state_err  (state_err),
  .ft_active  (ft_active)
);

// File: tb/tb_npc_ft_gate_sel.sv
module tb_npc_ft_gate_sel;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  req_state = 4'd0;
  logic        fault_vld = 1'b0;
  logic [3:0]  fault_code = 4'd0;
  logic [11:0] gate;
  logic        state_err;
  logic        ft_active;

  int checks = 0;
  int bad    = 0;

  always #10 clk = ~clk;

  npc_ft_gate_sel dut (
    .clk        (clk),
    .rst        (rst),
    .req_state  (req_state),
    .fault_vld  (fault_vld),
    .fault_code (fault_code),
    .gate       (gate),
    .state_err  (state_err),
    .ft_active  (ft_active)
  );

  // Patterns per state, from R2 and R3.
  function automatic logic [11:0] pat(input int s);
    case (s)
      1: return 12'hC30;  2: return 12'hC60;  3: return 12'h630;
      4: return 12'hCC0;  5: return 12'h660;  6: return 12'h330;
      7: return 12'h6C0;  8: return 12'h360;  9: return 12'h3C0;
      10: return 12'h038; 11: return 12'h068; 12: return 12'h0C4;
      13: return 12'h064; 14: return 12'h302; 15: return 12'h602;
      16: return 12'hC01; 17: return 12'h601;
      default: return 12'h000;
    endcase
  endfunction

  // Substitutions from R6, R7, R8.
  function automatic int remap(input int f, input int s);
    int r = s;
    case (f)
      1: case (s) 3: r = 2; 5: r = 4; 7: r = 8; default: ; endcase
      2: case (s) 2: r = 3; 5: r = 4; 8: r = 7; default: ; endcase
      3: case (s) 1: r = 10; 2: r = 11; 4: r = 5; default: ; endcase
      4: case (s) 1: r = 10; 2: r = 11; 3: r = 11; 4: r = 6; 5: r = 6; 7: r = 8; default: ; endcase
      5: case (s) 3: r = 2; 5: r = 4; 6: r = 4; 7: r = 13; 8: r = 13; 9: r = 12; default: ; endcase
      6: case (s) 6: r = 4; 8: r = 13; 9: r = 12; default: ; endcase
      7: case (s) 4: r = 5; 7: r = 15; 9: r = 14; default: ; endcase
      8: case (s) 2: r = 3; 4: r = 6; 5: r = 6; 7: r = 15; 8: r = 15; 9: r = 14; default: ; endcase
      9: case (s) 1: r = 16; 2: r = 17; 3: r = 17; 5: r = 4; 6: r = 4; 8: r = 7; default: ; endcase
      10: case (s) 1: r = 16; 3: r = 17; 6: r = 4; default: ; endcase
      default: ;
    endcase
    return r;
  endfunction

  // {fault, state, expected gate, expected err}; fault strobed with the request.
  localparam logic [20:0] VEC [12] = '{
    {4'd3,  4'd1,  12'h038, 1'b0}, {4'd3,  4'd2,  12'h068, 1'b0},
    {4'd6,  4'd9,  12'h0C4, 1'b0}, {4'd5,  4'd8,  12'h064, 1'b0},
    {4'd7,  4'd9,  12'h302, 1'b0}, {4'd8,  4'd7,  12'h602, 1'b0},
    {4'd9,  4'd1,  12'hC01, 1'b0}, {4'd10, 4'd3,  12'h601, 1'b0},
    {4'd1,  4'd5,  12'hCC0, 1'b0}, {4'd2,  4'd2,  12'h630, 1'b0},
    {4'd4,  4'd4,  12'h330, 1'b0}, {4'd0,  4'd12, 12'h000, 1'b1}
  };

  task automatic chk_out(input string tag, input logic [11:0] eg, input logic ee);
    checks++;
    if (gate !== eg || state_err !== ee) begin
      bad++;
      $display("FAIL %s: gate=%h err=%b expected gate=%h err=%b", tag, gate, state_err, eg, ee);
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(input int s, input logic v, input int f);
    @(negedge clk);
    req_state  = 4'(s);
    fault_vld  = v;
    fault_code = 4'(f);
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; fault_vld = 1'b0; req_state = 4'd0; fault_code = 4'd0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    // R1: reset holds outputs low even with live inputs
    @(negedge clk);
    req_state = 4'd1; fault_vld = 1'b1; fault_code = 4'd3;
    @(posedge clk); #2;
    chk_out("R1 reset outputs", 12'h000, 1'b0);
    chk_bit("R1 reset ft_active", ft_active, 1'b0);

    // R3 / R10: directed vectors, fault strobed in the same cycle as the request
    foreach (VEC[i]) begin
      do_reset();
      apply(int'(VEC[i][16:13]), 1'b1, int'(VEC[i][20:17]));
      chk_out($sformatf("R3 R10 vector %0d", i), VEC[i][12:1], VEC[i][0]);
    end

    // Full sweep: every fault code against every requested state (R2, R6..R9, R11)
    for (int f = 0; f <= 10; f++) begin
      do_reset();
      for (int s = 0; s < 16; s++) begin
        string tag;
        logic  e;
        e = (s == 0) || (s > 9);
        if (e)           tag = "R9";
        else if (f == 0) tag = "R2";
        else if (f < 3)  tag = "R6";
        else if (f < 7)  tag = "R7";
        else             tag = "R8";
        apply(s, 1'b1, f);
        chk_out($sformatf("%s fault=%0d state=%0d", tag, f, s), e ? 12'h000 : pat(remap(f, s)), e);
        chk_bit($sformatf("R11 shoot-through fault=%0d state=%0d", f, s),
                (gate[11] & gate[9]) | (gate[10] & gate[8]) | (gate[7] & gate[5]) | (gate[6] & gate[4]),
                1'b0);
      end
      chk_bit($sformatf("R4 ft_active fault=%0d", f), ft_active, f != 0);
    end

    // R5: second fault while latched is ignored
    do_reset();
    apply(1, 1'b1, 3);
    apply(1, 1'b1, 9);
    chk_out("R5 second fault ignored", 12'h038, 1'b0);
    apply(1, 1'b0, 0);
    chk_out("R5 first fault kept", 12'h038, 1'b0);

    // R5: out-of-range codes are not latched
    do_reset();
    apply(1, 1'b1, 11);
    apply(1, 1'b1, 15);
    chk_out("R5 code 15 ignored", 12'hC30, 1'b0);
    apply(1, 1'b0, 0);
    chk_bit("R5 ft_active after bad codes", ft_active, 1'b0);

    // R4: sticky over many cycles without strobe
    apply(6, 1'b1, 10);
    repeat (20) apply(9, 1'b0, 0);
    chk_bit("R4 sticky ft_active", ft_active, 1'b1);
    apply(6, 1'b0, 0);
    chk_out("R4 sticky mapping", 12'hCC0, 1'b0);

    // R1: reset clears the latched fault
    do_reset();
    apply(1, 1'b0, 0);
    chk_out("R1 fault cleared", 12'hC30, 1'b0);
    chk_bit("R1 ft_active cleared", ft_active, 1'b0);

    // R10: output holds until the edge after the input change
    apply(9, 1'b0, 0);
    @(negedge clk);
    req_state = 4'd1;
    #8;
    chk_out("R10 before edge", 12'h3C0, 1'b0);
    @(posedge clk); #2;
    chk_out("R10 after edge", 12'hC30, 1'b0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule